// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block is the piece of processor control that decides when an interrupt is taken and carries out the entry and exit steps around it. It watches one combined request line from the devices together with the interrupt-enable bit of the processor status word presented by the core. A request is never serviced in the middle of an instruction: the sequencer waits for the core to signal that the current instruction has completed. It then writes the return address and the status word onto a memory stack, looks up the handler address and hands the core a new program counter and a status word whose enable bit is cleared.

When the core completes a return-from-interrupt instruction it pulses a return strobe. The sequencer then reads the saved status word and return address back from the stack, in the opposite order to the pushes, and loads both into the core with the enable bit set again. The core, its datapath and its memory sit outside the block; memory is reached through a single request/ready port and the core through load strobes. Either a table of handler addresses indexed by a code from the device or a single fixed handler address can be chosen by parameter.

Top module: `irq_seq`

## Requirements
- R1: A request that is present and enabled while an instruction is still running starts no memory access and raises no busy until `insn_done` is seen high; the program counter pushed is the `pc_in` value of that `insn_done` cycle.
- R2: On entry the first access writes the zero-extended return address to SP-STEP, the second writes the status word to SP-2·STEP, where STEP is DW/8 bytes, and the stack pointer then stays lowered by two words; nested entries keep stacking downward.
- R3: Requests are accepted only while bit 9 of `ps_in` is 1; with that bit at 0 a held request causes no memory access, no `irq_ack` and no load, whatever the number of instruction boundaries.
- R4: Entry ends with one cycle in which `irq_ack`, `pc_load` and `ps_load` are all high, `ps_out` equals the saved status word with bit 9 cleared and every other bit unchanged; a request still held afterwards causes no second entry.
- R5: A `rti` pulse reads the status word at SP and then the return address at SP+STEP, raising the stack pointer by one word after each, and ends with `pc_load` and `ps_load` high, `pc_out` equal to the second word and `ps_out` equal to the first word with bit 9 forced to 1; `irq_ack` stays low.
- R6: In vectored mode the third entry access is a read of address VEC_BASE + code·STEP, using the `irq_code` present at the boundary, and the program counter loaded is the low AW bits of the word read.
- R7: Every memory access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until a cycle with `mem_ready` high, which completes it; any number of wait cycles is allowed.
- R8: A request withdrawn (or disabled) before the instruction boundary is abandoned with no memory access and no load.
- R9: `busy` is high from the first stack access until the final load cycle inclusive, and low while idle or waiting for a boundary.
- R10: After reset `mem_req`, `pc_load`, `ps_load`, `irq_ack` and `busy` are 0 and the stack pointer equals SP_INIT, so the first push goes to SP_INIT-STEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Combined interrupt request from all devices |
| irq_code | input | CODE_W | Device code selecting the vector table entry |
| insn_done | input | 1 | Current instruction completes this cycle |
| rti | input | 1 | Return-from-interrupt instruction completes this cycle |
| pc_in | input | AW | Program counter of the next instruction |
| ps_in | input | DW | Current processor status word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| pc_load | output | 1 | Load pc_out into the program counter |
| pc_out | output | AW | New program counter value |
| ps_load | output | 1 | Load ps_out into the status word |
| ps_out | output | DW | New status word value |
| irq_ack | output | 1 | Entry completes this cycle |
| busy | output | 1 | Sequencer owns the core; core must stall |

## Verification
The bench builds the block with AW = DW = 16, CODE_W = 3, vectored mode, SP_INIT = 0x8000 and a vector table at 0x0100, so each stack slot and table entry is a distinct 16-bit word in a small bench memory. A random stall pattern on `mem_ready` puts every access through wait cycles. Two nested entries followed by two returns exercise stack order across more than one frame. A saved status word rewritten in memory before the final return shows that the enable bit is forced on rather than merely restored.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAIT_BOUNDARY,
      ST_PUSH_PC,
      ST_PUSH_PS,
      ST_FETCH_VECTOR,
      ST_LOAD_PC,
      ST_POP_PS,
      ST_POP_PC
   } seq_state_t;

   typedef enum logic [1:0] {
      SP_HOLD,
      SP_DEC,
      SP_INC
   } sp_op_t;

endpackage

// File: rtl/irq_seq_sp.sv
module irq_seq_sp
   import irq_seq_pkg::*;
#(
   parameter int          AW      = 16,
   parameter int          STEP    = 2,
   parameter int unsigned SP_INIT = 32'h8000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  sp_op_t        op,
   output logic [AW-1:0] sp,
   output logic [AW-1:0] sp_dec
);

   localparam logic [AW-1:0] INIT_V = AW'(SP_INIT);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp <= INIT_V;
      end else begin
         unique case (op)
            SP_DEC:  sp <= sp - STEP_V;
            SP_INC:  sp <= sp + STEP_V;
            default: sp <= sp;
         endcase
      end
   end

   assign sp_dec = sp - STEP_V;

endmodule

// File: rtl/irq_seq_vec.sv
module irq_seq_vec #(
   parameter int          AW       = 16,
   parameter int          CODE_W   = 3,
   parameter int          STEP     = 2,
   parameter bit          VECTORED = 1'b1,
   parameter int unsigned VEC_BASE = 32'h0100
) (
   input  logic [CODE_W-1:0] code,
   output logic [AW-1:0]     vec_addr
);

   localparam logic [AW-1:0] BASE_V = AW'(VEC_BASE);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   generate
      if (VECTORED) begin : g_table
         logic [AW-1:0] code_ext;
         assign code_ext = AW'(code);
         assign vec_addr = BASE_V + code_ext * STEP_V;
      end else begin : g_fixed
         logic unused_code;
         assign unused_code = ^code;
         assign vec_addr    = BASE_V;
      end
   endgenerate

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
   import irq_seq_pkg::*;
#(
   parameter int          AW          = 16,
   parameter int          DW          = 16,
   parameter int          CODE_W      = 3,
   parameter int          IE_BIT      = 9,
   parameter bit          NEED_FETCH  = 1'b1,
   parameter int unsigned FIXED_ENTRY = 32'h0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [CODE_W-1:0] irq_code,
   input  logic              insn_done,
   input  logic              rti,
   input  logic [AW-1:0]     pc_in,
   input  logic [DW-1:0]     ps_in,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_ready,
   input  logic [AW-1:0]     sp,
   input  logic [AW-1:0]     sp_dec,
   input  logic [AW-1:0]     vec_addr,
   output logic [CODE_W-1:0] code_q,
   output sp_op_t            sp_op,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic              pc_load,
   output logic [AW-1:0]     pc_out,
   output logic              ps_load,
   output logic [DW-1:0]     ps_out,
   output logic              irq_ack,
   output logic              busy
);

   localparam logic [DW-1:0] IE_MASK = DW'(1) << IE_BIT;
   localparam logic [AW-1:0] FIXED_V = AW'(FIXED_ENTRY);

   seq_state_t    state;
   logic [AW-1:0] pc_save;
   logic [DW-1:0] ps_save;
   logic [AW-1:0] vec_q;
   logic          take;

   assign take = irq_req & ps_in[IE_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pc_save <= '0;
         ps_save <= '0;
         vec_q   <= '0;
         code_q  <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_WAIT_BOUNDARY: begin
               if (rti) begin
                  state <= ST_POP_PS;
               end else if (!take) begin
                  state <= ST_IDLE;
               end else if (insn_done) begin
                  pc_save <= pc_in;
                  ps_save <= ps_in;
                  code_q  <= irq_code;
                  state   <= ST_PUSH_PC;
               end else begin
                  state <= ST_WAIT_BOUNDARY;
               end
            end
            ST_PUSH_PC: begin
               if (mem_ready) state <= ST_PUSH_PS;
            end
            ST_PUSH_PS: begin
               if (mem_ready) begin
                  if (NEED_FETCH) begin
                     state <= ST_FETCH_VECTOR;
                  end else begin
                     vec_q <= FIXED_V;
                     state <= ST_LOAD_PC;
                  end
               end
            end
            ST_FETCH_VECTOR: begin
               if (mem_ready) begin
                  vec_q <= mem_rdata[AW-1:0];
                  state <= ST_LOAD_PC;
               end
            end
            ST_LOAD_PC: begin
               state <= ST_IDLE;
            end
            ST_POP_PS: begin
               if (mem_ready) begin
                  ps_save <= mem_rdata;
                  state   <= ST_POP_PC;
               end
            end
            ST_POP_PC: begin
               if (mem_ready) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      sp_op     = SP_HOLD;
      pc_load   = 1'b0;
      pc_out    = '0;
      ps_load   = 1'b0;
      ps_out    = '0;
      irq_ack   = 1'b0;
      unique case (state)
         ST_PUSH_PC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_dec;
            mem_wdata = DW'(pc_save);
            if (mem_ready) sp_op = SP_DEC;
         end
         ST_PUSH_PS: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_dec;
            mem_wdata = ps_save;
            if (mem_ready) sp_op = SP_DEC;
         end
         ST_FETCH_VECTOR: begin
            mem_req  = 1'b1;
            mem_addr = vec_addr;
         end
         ST_LOAD_PC: begin
            pc_load = 1'b1;
            pc_out  = vec_q;
            ps_load = 1'b1;
            ps_out  = ps_save & ~IE_MASK;
            irq_ack = 1'b1;
         end
         ST_POP_PS: begin
            mem_req  = 1'b1;
            mem_addr = sp;
            if (mem_ready) sp_op = SP_INC;
         end
         ST_POP_PC: begin
            mem_req  = 1'b1;
            mem_addr = sp;
            if (mem_ready) begin
               sp_op   = SP_INC;
               pc_load = 1'b1;
               pc_out  = mem_rdata[AW-1:0];
               ps_load = 1'b1;
               ps_out  = ps_save | IE_MASK;
            end
         end
         default: ;
      endcase
   end

   assign busy = (state != ST_IDLE) && (state != ST_WAIT_BOUNDARY);

endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_seq_pkg::*;
#(
   parameter int          AW          = 16,
   parameter int          DW          = 16,
   parameter int          CODE_W      = 3,
   parameter int          IE_BIT      = 9,
   parameter bit          VECTORED    = 1'b1,
   parameter int unsigned SP_INIT     = 32'h8000,
   parameter int unsigned VEC_BASE    = 32'h0100,
   parameter int unsigned FIXED_ENTRY = 32'h0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [CODE_W-1:0] irq_code,
   input  logic              insn_done,
   input  logic              rti,
   input  logic [AW-1:0]     pc_in,
   input  logic [DW-1:0]     ps_in,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_ready,
   output logic              pc_load,
   output logic [AW-1:0]     pc_out,
   output logic              ps_load,
   output logic [DW-1:0]     ps_out,
   output logic              irq_ack,
   output logic              busy
);

   localparam int STEP = DW / 8;

   generate
      if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
         $error("irq_seq: DW must be a whole number of bytes");
      end
      if (AW > DW) begin : g_bad_aw
         $error("irq_seq: AW must not exceed DW");
      end
      if (IE_BIT < 0 || IE_BIT >= DW) begin : g_bad_ie
         $error("irq_seq: IE_BIT outside the status word");
      end
      if (CODE_W < 1) begin : g_bad_code
         $error("irq_seq: CODE_W must be at least 1");
      end
   endgenerate

   sp_op_t            sp_op;
   logic [AW-1:0]     sp;
   logic [AW-1:0]     sp_dec;
   logic [AW-1:0]     vec_addr;
   logic [CODE_W-1:0] code_q;

   irq_seq_sp #(
      .AW      (AW),
      .STEP    (STEP),
      .SP_INIT (SP_INIT)
   ) u_sp (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (sp_op),
      .sp     (sp),
      .sp_dec (sp_dec)
   );

   irq_seq_vec #(
      .AW       (AW),
      .CODE_W   (CODE_W),
      .STEP     (STEP),
      .VECTORED (VECTORED),
      .VEC_BASE (VEC_BASE)
   ) u_vec (
      .code     (code_q),
      .vec_addr (vec_addr)
   );

   irq_seq_fsm #(
      .AW          (AW),
      .DW          (DW),
      .CODE_W      (CODE_W),
      .IE_BIT      (IE_BIT),
      .NEED_FETCH  (VECTORED),
      .FIXED_ENTRY (FIXED_ENTRY)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_req   (irq_req),
      .irq_code  (irq_code),
      .insn_done (insn_done),
      .rti       (rti),
      .pc_in     (pc_in),
      .ps_in     (ps_in),
      .mem_rdata (mem_rdata),
      .mem_ready (mem_ready),
      .sp        (sp),
      .sp_dec    (sp_dec),
      .vec_addr  (vec_addr),
      .code_q    (code_q),
      .sp_op     (sp_op),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .pc_load   (pc_load),
      .pc_out    (pc_out),
      .ps_load   (ps_load),
      .ps_out    (ps_out),
      .irq_ack   (irq_ack),
      .busy      (busy)
   );

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
   parameter int AW     = 16,
   parameter int DW     = 16,
   parameter int IE_BIT = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_ready,
   input logic          pc_load,
   input logic          ps_load,
   input logic [DW-1:0] ps_out,
   input logic          irq_ack,
   input logic          busy
);

   assert_hold_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata)));

   assert_entry_clears_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (pc_load && ps_load && !ps_out[IE_BIT]));

   assert_return_sets_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && !irq_ack) |-> (ps_load && ps_out[IE_BIT]));

   assert_busy_on_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   assert_no_load_on_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !pc_load);

   assert_entry_ends_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !busy);

endmodule

bind irq_seq irq_seq_chk #(
   .AW     (AW),
   .DW     (DW),
   .IE_BIT (IE_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready),
   .pc_load   (pc_load),
   .ps_load   (ps_load),
   .ps_out    (ps_out),
   .irq_ack   (irq_ack),
   .busy      (busy)
);

// File: tb/irq_seq_bench.sv
module irq_seq_bench;

   localparam logic [15:0] IE = 16'h0200;

   typedef struct packed {
      logic        we;
      logic [15:0] addr;
      logic [15:0] data;
   } acc_t;

   typedef struct packed {
      logic [15:0] pc;
      logic [15:0] ps;
      logic        entry;
   } load_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic [2:0]  irq_code = '0;
   logic        insn_done = 1'b0;
   logic        rti = 1'b0;
   logic [15:0] pc = '0;
   logic [15:0] ps = '0;
   logic        mem_req, mem_we, pc_load, ps_load, irq_ack, busy;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_out, ps_out;
   logic        mem_ready = 1'b1;
   logic        stall_en = 1'b0;
   logic [15:0] mem [0:1023];

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int loads = 0;
   int acks = 0;
   logic [15:0] model_sp = 16'h8000;
   acc_t  exp_acc[$];
   load_t exp_load[$];
   logic [15:0] frame_pc[$];
   logic [15:0] frame_ps[$];

   always #5 clk = ~clk;

   irq_seq u_irq_seq (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_code(irq_code),
      .insn_done(insn_done), .rti(rti), .pc_in(pc), .ps_in(ps),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .pc_load(pc_load), .pc_out(pc_out), .ps_load(ps_load), .ps_out(ps_out),
      .irq_ack(irq_ack), .busy(busy)
   );

   function automatic int widx(logic [15:0] a);
      return int'(a[10:1]);
   endfunction

   assign mem_rdata = mem[widx(mem_addr)];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // memory, core registers and ready pattern
   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (mem_req && mem_we && mem_ready) mem[widx(mem_addr)] <= mem_wdata;
      if (pc_load) pc <= pc_out;
      if (ps_load) ps <= ps_out;
      mem_ready <= stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
   end

   // reference comparison on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && mem_ready) begin
            if (exp_acc.size() == 0) begin
               check("R1 R3 R8 unexpected access", {15'd0, mem_we, mem_addr}, 32'hFFFF_FFFF);
            end else begin
               acc_t e;
               e = exp_acc.pop_front();
               check("R2 R5 R6 access kind", {31'd0, mem_we}, {31'd0, e.we});
               check("R2 R5 R6 access address", {16'd0, mem_addr}, {16'd0, e.addr});
               if (e.we) check("R2 push data", {16'd0, mem_wdata}, {16'd0, e.data});
            end
         end
         if (mem_req && !busy) check("R9 busy during access", 0, 1);
         if (pc_load) begin
            loads++;
            if (irq_ack) acks++;
            if (exp_load.size() == 0) begin
               check("R3 R4 unexpected load", {16'd0, pc_out}, 32'hFFFF_FFFF);
            end else begin
               load_t l;
               l = exp_load.pop_front();
               check(l.entry ? "R6 entry pc" : "R5 return pc", {16'd0, pc_out}, {16'd0, l.pc});
               check(l.entry ? "R4 entry ps" : "R5 return ps", {16'd0, ps_out}, {16'd0, l.ps});
               check("R4 R5 ack and ps_load", {30'd0, irq_ack, ps_load}, {30'd0, l.entry, 1'b1});
            end
         end else if (irq_ack) begin
            check("R4 ack without load", 0, 1);
         end
      end
   end

   always @(posedge clk) begin
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic boundary();
      insn_done = 1'b1;
      step(1);
      insn_done = 1'b0;
   endtask

   task automatic wait_loads(int target);
      while (loads < target) step(1);
      step(1);
   endtask

   task automatic take_irq(logic [2:0] code, logic [15:0] pcb);
      logic [15:0] vaddr;
      int tgt;
      vaddr = 16'h0100 + 16'(code) * 16'd2;
      exp_acc.push_back('{1'b1, model_sp - 16'd2, pcb});
      exp_acc.push_back('{1'b1, model_sp - 16'd4, ps});
      exp_acc.push_back('{1'b0, vaddr, 16'h0000});
      exp_load.push_back('{mem[widx(vaddr)], ps & ~IE, 1'b1});
      frame_pc.push_back(pcb);
      frame_ps.push_back(ps);
      model_sp = model_sp - 16'd4;
      tgt = loads + 1;
      irq_req = 1'b1;
      irq_code = code;
      pc = pcb;
      step(3);
      check("R1 no busy before boundary", {31'd0, busy}, 0);
      boundary();
      wait_loads(tgt);
   endtask

   task automatic do_rti();
      logic [15:0] p, s;
      int tgt;
      p = frame_pc.pop_back();
      s = frame_ps.pop_back();
      exp_acc.push_back('{1'b0, model_sp, 16'h0000});
      exp_acc.push_back('{1'b0, model_sp + 16'd2, 16'h0000});
      exp_load.push_back('{p, s | IE, 1'b0});
      model_sp = model_sp + 16'd4;
      tgt = loads + 1;
      rti = 1'b1;
      step(1);
      rti = 1'b0;
      wait_loads(tgt);
      check("R5 core pc after return", {16'd0, pc}, {16'd0, p});
      check("R5 core ps after return", {16'd0, ps}, {16'd0, s | IE});
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
      for (int c = 0; c < 8; c++) mem[widx(16'h0100 + 16'(c) * 16'd2)] = 16'h4000 + 16'(c) * 16'h0010;
      step(3);
      // R10 reset state
      check("R10 reset outputs", {27'd0, mem_req, pc_load, ps_load, irq_ack, busy}, 0);
      rst_n = 1'b1;
      step(1);
      check("R10 idle after reset", {30'd0, mem_req, busy}, 0);
      stall_en = 1'b1;

      // R3: enable bit clear, held request ignored
      ps = 16'h0007;
      irq_req = 1'b1;
      irq_code = 3'd1;
      for (int k = 0; k < 4; k++) begin boundary(); step(1); end
      check("R3 no entry with enable 0", acks, 0);
      check("R3 no busy with enable 0", {31'd0, busy}, 0);
      irq_req = 1'b0;
      step(2);

      // R8: withdrawn before boundary
      ps = 16'h0207;
      irq_req = 1'b1;
      step(3);
      irq_req = 1'b0;
      step(1);
      boundary();
      step(3);
      check("R8 abandoned request", {31'd0, busy}, 0);
      check("R8 no load", loads, 0);

      // R1 R2 R6 R10 first entry, code 5
      take_irq(3'd5, 16'h1234);
      check("R6 core pc at handler", {16'd0, pc}, 32'h0000_4050);
      check("R4 core ps enable cleared", {16'd0, ps}, 32'h0000_0007);
      // R4: request still held, no re-entry
      for (int k = 0; k < 3; k++) begin boundary(); step(1); end
      check("R4 no re-entry", acks, 1);
      irq_req = 1'b0;

      // nested entry, code 7
      ps = 16'h0280;
      take_irq(3'd7, 16'h3456);
      check("R6 nested handler pc", {16'd0, pc}, 32'h0000_4070);
      irq_req = 1'b0;
      step(2);
      do_rti();

      // R5: saved status word rewritten without enable bit
      mem[widx(model_sp)] = 16'h0011;
      void'(frame_ps.pop_back());
      frame_ps.push_back(16'h0011);
      do_rti();
      check("R2 R5 stack balanced, no stray work", {31'd0, busy}, 0);
      check("R5 all expected accesses consumed", exp_acc.size(), 0);

      // fresh entry after returns reuses top of stack (R2)
      take_irq(3'd0, 16'h0042);
      irq_req = 1'b0;
      do_rti();
      step(4);
      check("R7 R9 queues empty at end", exp_acc.size() + exp_load.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule